// File: doc/BRIEF.md
# SPI Word Master

This block is a register-mapped SPI master that moves one word of 1 to 32 bits each time software issues a start. Software reaches it over a 32-bit word bus. It programs a control word that holds the enable bit, the master bit, the chip-select mode and the word length. A second control word holds the direction enables and the slave select. Software pushes data into a four-entry transmit queue, starts the word, polls the status word, and pops the captured word from a four-entry receive queue.

Each start takes one entry from the transmit queue. The block shifts it out most-significant bit first on a mode-0 serial clock: SCK idles low, MOSI changes on the falling edge and MISO is sampled on the rising edge. The word received during the shift is pushed into the receive queue, right-aligned. Chip select is either held low by software through a value bit, or driven by the engine for the duration of the word. Status events stay latched until software writes a one to them.

Top module: `spi_word_master`

## Requirements
- R1: After reset the status word (offset 0x08) reads 0x00A0_0000, which means busy clear, ready clear, both queues empty (bit 23 receive empty, bit 21 transmit empty) and no event flags. All chip-select lines are high and SCK is low.
- R2: A write to the control word (offset 0x00) with bit 31 (enable), bit 28 (master) and bit 30 (start) all set begins a transfer of L+1 bits, where L is bits 4:0 of the same write. SCK gives exactly L+1 rising edges, each half period lasting HALF_DIV clocks. MOSI carries bit L of the queued word first and bit 0 last, and SCK returns low when the word ends.
- R3: MISO is sampled on each SCK rising edge. The first sample lands in bit L of the received word and the last in bit 0, and the bits above L read zero. A read of offset 0x180 pops the oldest received word.
- R4: Status bit 31 (busy) is set from the cycle after the start until the word ends. At that point busy clears and bit 30 (ready) sets, and ready stays set until software clears it.
- R5: Writing the status word clears each event flag (bit 30 ready, 25 receive overflow, 24 transmit underrun, 19 transmit overflow, 18 receive underrun) whose bit in the write is 1. Flags whose bit is 0 are left unchanged.
- R6: A write of offset 0x100 pushes the transmit queue. The queue holds FIFO_DEPTH words, which are sent oldest first. Status bit 20 shows full and bit 21 shows empty. A push to a full queue is dropped and sets bit 19.
- R7: A word that completes while the receive queue is full is dropped and sets status bit 25. Bit 22 shows the receive queue full.
- R8: A start with transmit enabled and the transmit queue empty sets status bit 24 and shifts out all zeros.
- R9: A read of offset 0x180 with the receive queue empty returns 0 and sets status bit 18.
- R10: With control bit 11 set, the chip-select line chosen by second-control bits 19:18 is driven low when control bit 12 is 1 and high when it is 0. All other lines stay high.
- R11: With control bit 11 clear, the chosen chip-select line is low exactly while busy. All other lines stay high.
- R12: With second-control bit 30 (transmit enable) clear, a transfer pops nothing and shifts zeros. With bit 31 (receive enable) clear, the captured word is not queued.
- R13: A start is ignored while busy, or when the same write has bit 31 or bit 28 clear. Bit 30 of the control word always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low slave selects |

## Verification
Most internal faults in this block surface within one word time. A bad bit counter shows up as the wrong number of SCK rising edges and a truncated or extended word at the slave. It also moves the cycle in which busy falls. A shift register that starts or moves wrongly lands data in the wrong bit of the received word on the very next pop. A wrong queue pointer or count appears as words out of order, or as a full or empty status flag disagreeing with the number of pushes and pops. An event flag with a bad set or clear path is visible on the next status read after the triggering access.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned LEN_W  = 5;
  localparam int unsigned ADDR_W = 9;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_CTRL2 = 9'h004;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 9'h008;
  localparam logic [ADDR_W-1:0] OFS_TXQ   = 9'h100;
  localparam logic [ADDR_W-1:0] OFS_RXQ   = 9'h180;

  // control word bits
  localparam int unsigned C_EN     = 31;
  localparam int unsigned C_START  = 30;
  localparam int unsigned C_MASTER = 28;
  localparam int unsigned C_CSVAL  = 12;
  localparam int unsigned C_CSSW   = 11;
  // second control word bits
  localparam int unsigned C2_RXEN  = 31;
  localparam int unsigned C2_TXEN  = 30;
  localparam int unsigned C2_SEL   = 18;
  // status bits
  localparam int unsigned S_BUSY   = 31;
  localparam int unsigned S_READY  = 30;
  localparam int unsigned S_RXOVF  = 25;
  localparam int unsigned S_TXUNR  = 24;
  localparam int unsigned S_RXEMP  = 23;
  localparam int unsigned S_RXFUL  = 22;
  localparam int unsigned S_TXEMP  = 21;
  localparam int unsigned S_TXFUL  = 20;
  localparam int unsigned S_TXOVF  = 19;
  localparam int unsigned S_RXUNR  = 18;

  typedef struct packed {
    logic             en;
    logic             master;
    logic             cs_val;
    logic             cs_sw;
    logic [LEN_W-1:0] len;
  } ctrl_t;
endpackage

// File: rtl/spi_wm_fifo.sv
module spi_wm_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (do_push) wp_n = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_n = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  // R6: occupancy never exceeds the depth
  p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R6: a push into a full queue without a pop leaves it full
  p_drop_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);
endmodule

// File: rtl/spi_wm_shift.sv
module spi_wm_shift #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [DATA_W-1:0]           word,
  input  logic [$clog2(DATA_W)-1:0]   len,
  input  logic                        miso,
  output logic                        sck,
  output logic                        mosi,
  output logic                        busy,
  output logic                        done,
  output logic [DATA_W-1:0]           rx_word
);
  localparam int unsigned LW    = $clog2(DATA_W);
  localparam int unsigned DIV_W = $clog2(HALF_DIV + 1);
  localparam logic [LW-1:0]    TOP    = LW'(DATA_W - 1);
  localparam logic [DIV_W-1:0] DIVEND = DIV_W'(HALF_DIV - 1);

  logic              busy_q, busy_n, sck_q, sck_n;
  logic [DIV_W-1:0]  div_q, div_n;
  logic [LW:0]       bits_q, bits_n;
  logic [DATA_W-1:0] out_q, out_n, in_q, in_n;

  always_comb begin
    busy_n = busy_q;
    sck_n  = sck_q;
    div_n  = div_q;
    bits_n = bits_q;
    out_n  = out_q;
    in_n   = in_q;
    done   = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        sck_n  = 1'b0;
        div_n  = '0;
        bits_n = (LW+1)'(len) + (LW+1)'(1);
        out_n  = word << (TOP - len);
        in_n   = '0;
      end
    end else if (div_q == DIVEND) begin
      div_n = '0;
      if (!sck_q) begin
        sck_n  = 1'b1;
        in_n   = {in_q[DATA_W-2:0], miso};
        bits_n = bits_q - 1'b1;
      end else begin
        sck_n = 1'b0;
        if (bits_q == '0) begin
          busy_n = 1'b0;
          done   = 1'b1;
        end else begin
          out_n = out_q << 1;
        end
      end
    end else begin
      div_n = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      div_q  <= '0;
      bits_q <= '0;
      out_q  <= '0;
      in_q   <= '0;
    end else begin
      busy_q <= busy_n;
      sck_q  <= sck_n;
      div_q  <= div_n;
      bits_q <= bits_n;
      out_q  <= out_n;
      in_q   <= in_n;
    end
  end

  assign sck     = sck_q;
  assign busy    = busy_q;
  assign mosi    = busy_q && out_q[DATA_W-1];
  assign rx_word = in_q;

  // R2: the serial clock rests low whenever no word is in flight
  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // R2: an accepted start makes the engine busy on the next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R4: completion drops busy on the next cycle
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_wm_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned HALF_DIV   = 2,
  parameter int unsigned NUM_CS     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam int unsigned SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  ctrl_t            ctrl_q, ctrl_n;
  logic             rxen_q, txen_q;
  logic [SEL_W-1:0] sel_q;
  logic             ready_q, rxovf_q, txunr_q, txovf_q, rxunr_q;
  logic             ready_n, rxovf_n, txunr_n, txovf_n, rxunr_n;

  logic wr, rd, we_ctrl, we_ctrl2, we_stat;
  logic go, tx_push, tx_pop, rx_push, rx_pop;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic busy, done;
  logic [BUS_W-1:0] tx_head, rx_head, rx_word, start_word;

  assign wr       = bus_sel && bus_wr;
  assign rd       = bus_sel && !bus_wr;
  assign we_ctrl  = wr && (bus_addr == OFS_CTRL);
  assign we_ctrl2 = wr && (bus_addr == OFS_CTRL2);
  assign we_stat  = wr && (bus_addr == OFS_STAT);
  assign tx_push  = wr && (bus_addr == OFS_TXQ);
  assign rx_pop   = rd && (bus_addr == OFS_RXQ);

  assign go = we_ctrl && bus_wdata[C_START] && bus_wdata[C_EN]
              && bus_wdata[C_MASTER] && !busy;
  assign tx_pop     = go && txen_q && !tx_empty;
  assign start_word = tx_pop ? tx_head : '0;
  assign rx_push    = done && rxen_q;

  spi_wm_fifo #(.W(BUS_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata),
    .pop(tx_pop), .rdata(tx_head), .empty(tx_empty), .full(tx_full));

  spi_wm_fifo #(.W(BUS_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
    .pop(rx_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full));

  spi_wm_shift #(.DATA_W(BUS_W), .HALF_DIV(HALF_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(go), .word(start_word),
    .len(bus_wdata[LEN_W-1:0]), .miso(spi_miso), .sck(spi_sck),
    .mosi(spi_mosi), .busy(busy), .done(done), .rx_word(rx_word));

  // next-state for control and event flags (set wins over clear)
  always_comb begin
    ctrl_n.en     = bus_wdata[C_EN];
    ctrl_n.master = bus_wdata[C_MASTER];
    ctrl_n.cs_val = bus_wdata[C_CSVAL];
    ctrl_n.cs_sw  = bus_wdata[C_CSSW];
    ctrl_n.len    = bus_wdata[LEN_W-1:0];
    ready_n = (ready_q & ~(we_stat & bus_wdata[S_READY])) | done;
    rxovf_n = (rxovf_q & ~(we_stat & bus_wdata[S_RXOVF])) | (rx_push & rx_full);
    txunr_n = (txunr_q & ~(we_stat & bus_wdata[S_TXUNR])) | (go & txen_q & tx_empty);
    txovf_n = (txovf_q & ~(we_stat & bus_wdata[S_TXOVF])) | (tx_push & tx_full);
    rxunr_n = (rxunr_q & ~(we_stat & bus_wdata[S_RXUNR])) | (rx_pop & rx_empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      rxen_q  <= 1'b0;
      txen_q  <= 1'b0;
      sel_q   <= '0;
      ready_q <= 1'b0;
      rxovf_q <= 1'b0;
      txunr_q <= 1'b0;
      txovf_q <= 1'b0;
      rxunr_q <= 1'b0;
    end else begin
      if (we_ctrl) ctrl_q <= ctrl_n;
      if (we_ctrl2) begin
        rxen_q <= bus_wdata[C2_RXEN];
        txen_q <= bus_wdata[C2_TXEN];
        sel_q  <= bus_wdata[C2_SEL +: SEL_W];
      end
      ready_q <= ready_n;
      rxovf_q <= rxovf_n;
      txunr_q <= txunr_n;
      txovf_q <= txovf_n;
      rxunr_q <= rxunr_n;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign spi_cs_n[i] = !((sel_q == SEL_W'(i)) &&
                           (ctrl_q.cs_sw ? ctrl_q.cs_val : busy));
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[C_EN]        = ctrl_q.en;
        bus_rdata[C_MASTER]    = ctrl_q.master;
        bus_rdata[C_CSVAL]     = ctrl_q.cs_val;
        bus_rdata[C_CSSW]      = ctrl_q.cs_sw;
        bus_rdata[LEN_W-1:0]   = ctrl_q.len;
      end
      OFS_CTRL2: begin
        bus_rdata[C2_RXEN]          = rxen_q;
        bus_rdata[C2_TXEN]          = txen_q;
        bus_rdata[C2_SEL +: SEL_W]  = sel_q;
      end
      OFS_STAT: begin
        bus_rdata[S_BUSY]  = busy;
        bus_rdata[S_READY] = ready_q;
        bus_rdata[S_RXOVF] = rxovf_q;
        bus_rdata[S_TXUNR] = txunr_q;
        bus_rdata[S_RXEMP] = rx_empty;
        bus_rdata[S_RXFUL] = rx_full;
        bus_rdata[S_TXEMP] = tx_empty;
        bus_rdata[S_TXFUL] = tx_full;
        bus_rdata[S_TXOVF] = txovf_q;
        bus_rdata[S_RXUNR] = rxunr_q;
      end
      OFS_RXQ:  bus_rdata = rx_empty ? '0 : rx_head;
      default:  bus_rdata = '0;
    endcase
  end

  // R4: a finished word always leaves ready set
  p_ready_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ready_q);
  // R10: never more than one slave selected
  p_cs_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~spi_cs_n) <= 1);
  // R11: under engine control a toggling clock always has a slave selected
  p_cs_during_sck_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.cs_sw && spi_sck) |-> !(&spi_cs_n));
  // R8: a start on an empty enabled transmit queue raises underrun
  p_underrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && txen_q && tx_empty) |=> txunr_q);
endmodule

// File: tb/sim_spi_word_master.sv
module sim_spi_word_master;
  import spi_wm_pkg::*;

  logic        clk, rst_n;
  logic        bus_sel, bus_wr;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        spi_sck, spi_mosi, spi_miso;
  logic [3:0]  spi_cs_n;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  spi_word_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // slave model: mode 0
  logic [31:0] slv_rx = '0;
  logic [31:0] miso_word = '0;
  int rises = 0;
  int falls = 0;
  int fall_base = 0;
  always @(posedge spi_sck) begin
    slv_rx <= {slv_rx[30:0], spi_mosi};
    rises  <= rises + 1;
  end
  always @(negedge spi_sck) falls <= falls + 1;
  logic [31:0] miso_idx;
  assign miso_idx = 32'(falls - fall_base);
  assign spi_miso = (miso_idx < 32) ? miso_word[5'(31 - miso_idx)] : 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    bit idle = 0;
    for (int k = 0; k < 1000 && !idle; k++) begin
      bus_read(OFS_STAT, s);
      idle = !s[31];
    end
    if (!idle) chk("R4 busy stuck", 32'd1, 32'd0);
  endtask

  // start one word; returns bits seen by the slave and rising edge count
  task automatic xfer(input logic [4:0] len, input logic [31:0] mval,
                      input logic [31:0] extra, output logic [31:0] seen,
                      output int nrise);
    int r0;
    miso_word = mval << (31 - len);
    fall_base = falls;
    r0 = rises;
    bus_write(OFS_CTRL, 32'hD000_0000 | extra | {27'd0, len});
    wait_idle();
    seen  = slv_rx;
    nrise = rises - r0;
  endtask

  task automatic t_reset();
    logic [31:0] s;
    bus_read(OFS_STAT, s);
    chk("R1 status after reset", s, 32'h00A0_0000);
    chk("R1 cs lines", {28'd0, spi_cs_n}, 32'hF);
    chk("R1 sck idle", {31'd0, spi_sck}, 32'd0);
  endtask

  task automatic t_basic();
    logic [31:0] s, seen, d;
    int n;
    bus_write(OFS_CTRL2, 32'hC000_0000 | (32'd1 << 18));
    bus_write(OFS_TXQ, 32'h0000_00A5);
    bus_read(OFS_STAT, s);
    chk("R6 tx not empty after push", {31'd0, s[21]}, 32'd0);
    miso_word = 32'h3C << 24;
    fall_base = falls;
    n = rises;
    bus_write(OFS_CTRL, 32'hD000_0007);
    repeat (3) @(negedge clk);
    chk("R11 hw cs low while busy", {28'd0, spi_cs_n}, 32'hD);
    chk("R4 busy during word", {31'd0, bus_rdata_stat_busy()}, 32'd1);
    wait_idle();
    chk("R2 eight rising edges", 32'(rises - n), 32'd8);
    chk("R2 msb-first byte", slv_rx & 32'hFF, 32'hA5);
    chk("R11 hw cs released", {28'd0, spi_cs_n}, 32'hF);
    chk("R2 sck low after word", {31'd0, spi_sck}, 32'd0);
    bus_read(OFS_STAT, s);
    chk("R4 ready set busy clear", s & 32'hC000_0000, 32'h4000_0000);
    bus_read(OFS_RXQ, d);
    chk("R3 received byte", d, 32'h3C);
    // full 32-bit word
    bus_write(OFS_TXQ, 32'h1234_5678);
    xfer(5'd31, 32'hCAFE_F00D, 32'd0, seen, n);
    chk("R2 32 rising edges", 32'(n), 32'd32);
    chk("R2 32-bit word out", seen, 32'h1234_5678);
    bus_read(OFS_RXQ, d);
    chk("R3 32-bit word in", d, 32'hCAFE_F00D);
    // odd 5-bit length
    bus_write(OFS_TXQ, 32'hFFFF_FF16);
    xfer(5'd4, 32'h0B, 32'd0, seen, n);
    chk("R2 five rising edges", 32'(n), 32'd5);
    chk("R2 5-bit word out", seen & 32'h1F, 32'h16);
    bus_read(OFS_RXQ, d);
    chk("R3 5-bit word right aligned", d, 32'h0B);
  endtask

  function automatic logic bus_rdata_stat_busy();
    return u0.spi_sck | !(&spi_cs_n);
  endfunction

  task automatic t_w1c();
    logic [31:0] s;
    bus_write(OFS_STAT, 32'h0000_0000);
    bus_read(OFS_STAT, s);
    chk("R5 ready kept on zero write", {31'd0, s[30]}, 32'd1);
    bus_write(OFS_STAT, 32'h4000_0000);
    bus_read(OFS_STAT, s);
    chk("R5 ready cleared by one", {31'd0, s[30]}, 32'd0);
  endtask

  task automatic t_queues();
    logic [31:0] s, seen, d;
    int n;
    for (int k = 0; k < 5; k++) bus_write(OFS_TXQ, 32'h11 * (k + 1));
    bus_read(OFS_STAT, s);
    chk("R6 tx full flag", {31'd0, s[20]}, 32'd1);
    chk("R6 tx overflow flag", {31'd0, s[19]}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      xfer(5'd7, 32'h40 + k, 32'd0, seen, n);
      chk("R6 tx order", seen & 32'hFF, 32'h11 * (k + 1));
    end
    bus_read(OFS_STAT, s);
    chk("R7 rx full flag", {31'd0, s[22]}, 32'd1);
    chk("R6 tx empty after four", {31'd0, s[21]}, 32'd1);
    xfer(5'd7, 32'h99, 32'd0, seen, n);
    chk("R8 zeros on underrun", seen & 32'hFF, 32'h00);
    bus_read(OFS_STAT, s);
    chk("R8 underrun flag", {31'd0, s[24]}, 32'd1);
    chk("R7 rx overflow flag", {31'd0, s[25]}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      bus_read(OFS_RXQ, d);
      chk("R7 rx order kept", d, 32'h40 + k);
    end
    bus_read(OFS_RXQ, d);
    chk("R9 empty pop returns zero", d, 32'd0);
    bus_read(OFS_STAT, s);
    chk("R9 rx underrun flag", {31'd0, s[18]}, 32'd1);
    bus_write(OFS_STAT, s);
    bus_read(OFS_STAT, s);
    chk("R5 write-back clears all events", s & 32'h4308_0000 | (s & 32'h0004_0000), 32'd0);
  endtask

  task automatic t_soft_cs();
    bus_write(OFS_CTRL2, 32'hC000_0000 | (32'd2 << 18));
    bus_write(OFS_CTRL, 32'h9000_1807);
    chk("R10 soft cs low", {28'd0, spi_cs_n}, 32'hB);
    bus_write(OFS_CTRL, 32'h9000_0807);
    chk("R10 soft cs high", {28'd0, spi_cs_n}, 32'hF);
  endtask

  task automatic t_dir_off();
    logic [31:0] s, seen, d;
    int n;
    bus_write(OFS_CTRL2, 32'h0000_0000);
    bus_write(OFS_TXQ, 32'h77);
    xfer(5'd7, 32'h5A, 32'd0, seen, n);
    chk("R12 zeros with tx off", seen & 32'hFF, 32'h00);
    bus_read(OFS_STAT, s);
    chk("R12 tx entry kept", {31'd0, s[21]}, 32'd0);
    chk("R12 rx not queued", {31'd0, s[23]}, 32'd1);
    chk("R12 no underrun with tx off", {31'd0, s[24]}, 32'd0);
    bus_write(OFS_CTRL2, 32'hC000_0000);
    xfer(5'd7, 32'h5A, 32'd0, seen, n);
    chk("R12 held word sent later", seen & 32'hFF, 32'h77);
    bus_read(OFS_RXQ, d);
    chk("R12 rx queued when on", d, 32'h5A);
  endtask

  task automatic t_go_ignore();
    logic [31:0] s, d;
    int r0;
    r0 = rises;
    bus_write(OFS_CTRL, 32'h5000_0007);
    repeat (6) @(negedge clk);
    bus_read(OFS_STAT, s);
    chk("R13 no start without enable", {31'd0, s[31]}, 32'd0);
    bus_write(OFS_CTRL, 32'hC000_0007);
    repeat (6) @(negedge clk);
    chk("R13 no start without master", 32'(rises - r0), 32'd0);
    bus_write(OFS_TXQ, 32'h01);
    bus_write(OFS_TXQ, 32'h02);
    miso_word = 32'h0;
    fall_base = falls;
    r0 = rises;
    bus_write(OFS_CTRL, 32'hD000_0007);
    bus_write(OFS_CTRL, 32'hD000_0007);
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R13 start while busy ignored", 32'(rises - r0), 32'd8);
    bus_read(OFS_STAT, s);
    chk("R13 second word still queued", {31'd0, s[21]}, 32'd0);
    bus_read(OFS_CTRL, d);
    chk("R13 start bit reads zero", {31'd0, d[30]}, 32'd0);
  endtask

  initial begin
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_w1c();
    t_queues();
    t_soft_cs();
    t_dir_off();
    t_go_ignore();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule